// File: doc/BRIEF.md
# CPU Clock Enable and Power-Mode Controller

This block produces the clock enables for a processor core and for its peripherals. Each enable is a single-cycle pulse taken from a programmable divider. The divider has two possible sources. The bypass source is the oscillator path, programmed by one divisor field, and it gives roughly 7.68 MHz after reset. The PLL source is programmed by a second divisor field. The PLL source can only be entered while the PLL reports lock. If lock is lost, or if bypass is requested again, the block falls back to the bypass source on the next cycle.

On top of the source choice, a three-state mode machine is applied: run, idle and power-down. In idle the core enable is held low while the peripheral enable keeps pulsing. In power-down both enables are held low. A power-down strobe only takes effect while the NMI level is low. A wake-up event brings the block back to run from either low-power state.

The source machine has two states. SRC_BYP goes to SRC_PLL on "select-PLL", which means the bypass bit is clear and lock is present. SRC_PLL goes back to SRC_BYP on "fallback", which means lock is lost or the bypass bit is set. The mode machine has three states, and it leaves each one on a named event:
- MODE_RUN goes to MODE_PDN on "power-down entry", which is a power-down strobe while NMI is low.
- MODE_RUN goes to MODE_IDLE on "idle entry", which is an idle strobe.
- MODE_IDLE goes to MODE_RUN on "wake".
- MODE_PDN goes to MODE_RUN on "wake".

Top module: `cpu_clk_pm`

## Requirements
- R1: While reset is asserted and directly after its release, `mode` reads 2'b00 (run) and `src_pll` reads 0 (bypass source).
- R2: With `src_pll` at 0, `per_en` pulses once every `osc_div`+1 cycles.
- R3: `src_pll` rises one cycle after `byp_req`=0 and `pll_lock`=1 are both present. While `pll_lock` is 0, `src_pll` stays 0 whatever `byp_req` is.
- R4: With `src_pll` at 1, `per_en` pulses once every `pll_div`+1 cycles.
- R5: While `src_pll` is 1, a low `pll_lock` or a high `byp_req` forces `src_pll` to 0 on the following cycle.
- R6: In run mode `cpu_en` equals `per_en` on every cycle, and `cpu_en` is never high while `per_en` is low.
- R7: An `idle_stb` pulse in run sets `mode` to 2'b01 one cycle later. In idle `cpu_en` stays 0 while `per_en` keeps pulsing.
- R8: A `pdn_stb` pulse in run with `nmi` low sets `mode` to 2'b10 one cycle later, after which both enables stay 0. With `nmi` high the strobe has no effect. When both strobes arrive in the same cycle, power-down wins.
- R9: `wake` in idle or power-down returns `mode` to 2'b00 one cycle later. `wake` in run has no effect. Strobes are ignored outside run.
- R10: A divisor change takes effect only at the next divided-period boundary. The period in progress finishes with the old divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byp_req | input | 1 | 1 requests the bypass source, 0 requests the PLL source |
| pll_lock | input | 1 | PLL output is stable |
| osc_div | input | DIV_W | Bypass divisor field (period = value + 1) |
| pll_div | input | DIV_W | PLL divisor field (period = value + 1) |
| idle_stb | input | 1 | Idle instruction strobe |
| pdn_stb | input | 1 | Power-down instruction strobe |
| nmi | input | 1 | NMI level, must be low for power-down |
| wake | input | 1 | Wake-up event |
| cpu_en | output | 1 | Core clock enable pulse |
| per_en | output | 1 | Peripheral clock enable pulse |
| mode | output | 2 | 00 run, 01 idle, 10 power-down |
| src_pll | output | 1 | 1 while the PLL source is in use |

## Verification
The assertions check the invariants on every cycle:
- the PLL source is only entered with lock present, and it is left the cycle after lock is lost;
- power-down is never entered with NMI high;
- the core enable never leads the peripheral enable;
- both enables stay silent in power-down.

Only the bench scenarios can show the divided periods for each source and divisor, the old period finishing after a divisor change, the idle window in which the peripheral keeps pulsing, and the strobes and wake events that the mode machine ignores.

// File: rtl/cpu_clk_pm_pkg.sv
package cpu_clk_pm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_IDLE = 2'b01,
        MODE_PDN  = 2'b10
    } pm_mode_e;

    typedef enum logic {
        SRC_BYP = 1'b0,
        SRC_PLL = 1'b1
    } clk_src_e;

endpackage

// File: rtl/cpu_clk_pm_src.sv
module cpu_clk_pm_src
    import cpu_clk_pm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byp_req,
    input  logic pll_lock,
    output logic use_pll
);

    clk_src_e src_q, src_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= SRC_BYP;
        else        src_q <= src_d;
    end

    // transitions: select-PLL and fallback
    always_comb begin
        src_d = src_q;
        unique case (src_q)
            SRC_BYP: if (!byp_req && pll_lock) src_d = SRC_PLL;
            SRC_PLL: if (byp_req || !pll_lock) src_d = SRC_BYP;
            default: src_d = SRC_BYP;
        endcase
    end

    // outputs
    always_comb begin
        use_pll = (src_q == SRC_PLL);
    end

    // R3
    pll_entry_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_pll) |-> $past(pll_lock));

    // R5
    pll_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_pll && !pll_lock) |=> !use_pll);

endmodule

// File: rtl/cpu_clk_pm_div.sv
module cpu_clk_pm_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // The count restarts from div_val only at a boundary, so a new value
    // lets the current period finish first.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == '0)  cnt_q <= div_val;
        else                   cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        tick = (cnt_q == '0);
    end

endmodule

// File: rtl/cpu_clk_pm_mode.sv
module cpu_clk_pm_mode
    import cpu_clk_pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_stb,
    input  logic       pdn_stb,
    input  logic       nmi,
    input  logic       wake,
    output logic [1:0] mode_o,
    output logic       cpu_gate,
    output logic       per_gate
);

    pm_mode_e st_q, st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MODE_RUN;
        else        st_q <= st_d;
    end

    // transitions: power-down entry, idle entry, wake
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MODE_RUN: begin
                if (pdn_stb && !nmi) st_d = MODE_PDN;
                else if (idle_stb)   st_d = MODE_IDLE;
            end
            MODE_IDLE: if (wake) st_d = MODE_RUN;
            MODE_PDN:  if (wake) st_d = MODE_RUN;
            default:   st_d = MODE_RUN;
        endcase
    end

    // outputs
    always_comb begin
        mode_o   = st_q;
        cpu_gate = (st_q == MODE_RUN);
        per_gate = (st_q != MODE_PDN);
    end

    // R8
    pdn_needs_nmi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != MODE_PDN && st_d == MODE_PDN) |-> !nmi);

    // R9
    wake_from_low_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != MODE_RUN && wake) |=> (mode_o == 2'b00));

endmodule

// File: rtl/cpu_clk_pm.sv
module cpu_clk_pm #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byp_req,
    input  logic             pll_lock,
    input  logic [DIV_W-1:0] osc_div,
    input  logic [DIV_W-1:0] pll_div,
    input  logic             idle_stb,
    input  logic             pdn_stb,
    input  logic             nmi,
    input  logic             wake,
    output logic             cpu_en,
    output logic             per_en,
    output logic [1:0]       mode,
    output logic             src_pll
);

    logic             use_pll;
    logic             tick;
    logic             cpu_gate;
    logic             per_gate;
    logic [DIV_W-1:0] div_sel;

    cpu_clk_pm_src u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .byp_req  (byp_req),
        .pll_lock (pll_lock),
        .use_pll  (use_pll)
    );

    always_comb begin
        div_sel = use_pll ? pll_div : osc_div;
    end

    cpu_clk_pm_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (div_sel),
        .tick    (tick)
    );

    cpu_clk_pm_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_stb (idle_stb),
        .pdn_stb  (pdn_stb),
        .nmi      (nmi),
        .wake     (wake),
        .mode_o   (mode),
        .cpu_gate (cpu_gate),
        .per_gate (per_gate)
    );

    always_comb begin
        cpu_en  = tick && cpu_gate;
        per_en  = tick && per_gate;
        src_pll = use_pll;
    end

    // R6
    cpu_follows_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> per_en);

    // R8
    pdn_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> (!per_en && !cpu_en));

    // R7
    idle_cpu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> !cpu_en);

endmodule

// File: tb/tb_cpu_clk_pm.sv
module tb_cpu_clk_pm;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 4;

    typedef struct packed {
        logic             byp;
        logic [DIV_W-1:0] odiv;
        logic [DIV_W-1:0] pdiv;
        logic             exp_src;
        logic [7:0]       exp_per;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 4'd3, 4'd5, 1'b0, 8'd4},
        '{1'b1, 4'd0, 4'd5, 1'b0, 8'd1},
        '{1'b0, 4'd2, 4'd6, 1'b1, 8'd7},
        '{1'b0, 4'd5, 4'd1, 1'b1, 8'd2},
        '{1'b1, 4'd6, 4'd1, 1'b0, 8'd7}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic byp_req, pll_lock, idle_stb, pdn_stb, nmi, wake;
    logic [DIV_W-1:0] osc_div, pll_div;
    logic cpu_en, per_en, src_pll;
    logic [1:0] mode;

    int n_chk  = 0;
    int n_fail = 0;
    int mism   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_clk_pm #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .byp_req(byp_req), .pll_lock(pll_lock),
        .osc_div(osc_div), .pll_div(pll_div), .idle_stb(idle_stb),
        .pdn_stb(pdn_stb), .nmi(nmi), .wake(wake), .cpu_en(cpu_en),
        .per_en(per_en), .mode(mode), .src_pll(src_pll)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (mode == 2'b00 && cpu_en != per_en) mism++;
    endtask

    task automatic wait_pulse();
        for (int i = 0; i < 100; i++) begin
            step();
            if (per_en) break;
        end
    endtask

    task automatic measure(output int n);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            step();
            n++;
            if (per_en) break;
        end
    endtask

    task automatic strobe(input int which);
        idle_stb = (which == 1 || which == 3);
        pdn_stb  = (which == 2 || which == 3);
        wake     = (which == 4);
        @(negedge clk);
        idle_stb = 1'b0; pdn_stb = 1'b0; wake = 1'b0;
    endtask

    task automatic count_pulses(input int cyc, output int nc, output int np);
        nc = 0; np = 0;
        for (int i = 0; i < cyc; i++) begin
            step();
            if (cpu_en) nc++;
            if (per_en) np++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int p, nc, np;
        rst_n = 1'b0; byp_req = 1'b1; pll_lock = 1'b0; osc_div = 4'd3; pll_div = 4'd5;
        idle_stb = 1'b0; pdn_stb = 1'b0; nmi = 1'b1; wake = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mode in reset", int'(mode), 0);
        chk("R1 src in reset", int'(src_pll), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode after reset", int'(mode), 0);
        chk("R1 src after reset", int'(src_pll), 0);

        // table walk: R2 / R4 source and period
        pll_lock = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            byp_req = VECS[v].byp;
            osc_div = VECS[v].odiv;
            pll_div = VECS[v].pdiv;
            wait_pulse();
            wait_pulse();
            chk(VECS[v].exp_src ? "R4 src flag" : "R2 src flag",
                int'(src_pll), int'(VECS[v].exp_src));
            measure(p);
            chk(VECS[v].exp_src ? "R4 period" : "R2 period", p, int'(VECS[v].exp_per));
        end
        chk("R6 cpu_en equals per_en in run", mism, 0);

        // R3 interlock
        byp_req = 1'b1; osc_div = 4'd1;
        @(negedge clk);
        pll_lock = 1'b0; byp_req = 1'b0;
        begin
            int hi;
            hi = 0;
            for (int i = 0; i < 20; i++) begin
                step();
                if (src_pll) hi++;
            end
            chk("R3 no PLL without lock", hi, 0);
        end
        pll_lock = 1'b1;
        @(negedge clk);
        chk("R3 PLL one cycle after lock", int'(src_pll), 1);

        // R5 fallback on lock loss and on bypass request
        pll_lock = 1'b0;
        @(negedge clk);
        chk("R5 fallback on lock loss", int'(src_pll), 0);
        pll_lock = 1'b1;
        @(negedge clk);
        chk("R3 PLL reselected", int'(src_pll), 1);
        byp_req = 1'b1;
        @(negedge clk);
        chk("R5 fallback on bypass request", int'(src_pll), 0);

        // R10 divisor change lands on boundary
        osc_div = 4'd7;
        wait_pulse(); wait_pulse();
        p = 0;
        step(); p++;
        osc_div = 4'd1;
        for (int i = 0; i < 100; i++) begin
            step(); p++;
            if (per_en) break;
        end
        chk("R10 old period completes", p, 8);
        measure(p);
        chk("R10 new period after boundary", p, 2);

        // R7 idle
        strobe(1);
        chk("R7 mode idle", int'(mode), 1);
        count_pulses(40, nc, np);
        chk("R7 cpu_en off in idle", nc, 0);
        chk("R7 per_en pulses in idle", np, 20);
        // R9 strobes ignored outside run
        nmi = 1'b0;
        strobe(2);
        chk("R9 pdn strobe ignored in idle", int'(mode), 1);
        strobe(4);
        chk("R9 wake from idle", int'(mode), 0);
        strobe(4);
        chk("R9 wake in run no effect", int'(mode), 0);

        // R8 power-down gated by nmi
        nmi = 1'b1;
        strobe(2);
        chk("R8 pdn ignored with nmi high", int'(mode), 0);
        nmi = 1'b0;
        strobe(3);
        chk("R8 pdn wins over idle", int'(mode), 2);
        count_pulses(40, nc, np);
        chk("R8 cpu_en off in power-down", nc, 0);
        chk("R8 per_en off in power-down", np, 0);
        strobe(1);
        chk("R9 idle strobe ignored in power-down", int'(mode), 2);
        strobe(4);
        chk("R9 wake from power-down", int'(mode), 0);
        count_pulses(20, nc, np);
        chk("R6 enables match after wake", nc, np);
        chk("R6 per_en resumes after wake", np, 10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule